// File: doc/BRIEF.md
# Reset Sequencer with Boot-Mode Strap and Shared Non-Maskable Interrupt Pin

This block sits between the chip's external reset and strap pins and the processor core. It asserts internal reset as soon as the external reset input goes low, without waiting for a clock edge. When the external reset is released, it passes the release through a flop synchronizer. It then keeps the core in reset for a fixed number of further clock ticks. On the cycle the core is let go, it samples the three mode straps into an operating-mode register. On that same cycle it samples the PLL-init strap into the PLL-enable control bit. Software may later rewrite the operating mode through a plain write strobe.

One of the three mode straps has a second job. A fixed number of cycles after the core leaves reset, that pin stops being a strap and becomes an active-low, falling-edge, non-maskable interrupt request. The pin is synchronized, and a high-to-low transition sets a sticky pending flag. That flag stays set until the interrupt controller returns an acknowledge pulse. The request always runs at priority level 3, and no mask input exists that could block it. Any new external reset puts the pin back into its strap role.

There is no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `reset_mode_nmi`

## Requirements
- R1: While `ext_rst_n` is low, the block asynchronously holds `core_rst_n`, `nmi_role`, `nmi_pending`, `op_mode` and `pll_pen` at 0.
- R2: After `ext_rst_n` rises, `core_rst_n` stays low for 2 synchronizer cycles plus HOLD_CYCLES (8) cycles, and rises after the 10th rising clock edge.
- R3: On the edge where `core_rst_n` rises, `op_mode` is loaded with {`modc_nmi_n`, `mode_b`, `mode_a`}. Bit 2 is the shared pin, bit 1 is mode B and bit 0 is mode A.
- R4: On that same edge, `pll_pen` is loaded with the value of `pll_init`.
- R5: While `core_rst_n` is high, `sw_mode_we` loads `sw_mode_wdata` into `op_mode` on the next edge. While `core_rst_n` is low, the write is ignored.
- R6: `nmi_role` rises SWITCH_CYCLES (4) edges after `core_rst_n` rises, and stays low whenever `core_rst_n` is low.
- R7: In the interrupt role, a falling edge on `modc_nmi_n` sets `nmi_pending` 3 rising edges after the pin changes (2 synchronizer flops plus the edge stage). A rising edge never sets it.
- R8: `nmi_pending` remains set for as long as no acknowledge arrives.
- R9: A one-cycle `nmi_ack` clears `nmi_pending`. If a new falling edge is detected on the same edge as the acknowledge, the flag stays set.
- R10: A low level or a falling edge on the shared pin before `nmi_role` rises never sets `nmi_pending`.
- R11: `nmi_level` reports the fixed priority 3 (binary 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| ext_rst_n | input | 1 | External hardware reset, active low, asynchronous assert |
| mode_a | input | 1 | Mode strap A |
| mode_b | input | 1 | Mode strap B |
| modc_nmi_n | input | 1 | Mode strap C during reset, active-low NMI request afterwards |
| pll_init | input | 1 | PLL-init strap |
| sw_mode_we | input | 1 | Software write strobe for the operating mode |
| sw_mode_wdata | input | 3 | Software value for the operating mode |
| nmi_ack | input | 1 | Acknowledge pulse from the interrupt controller |
| core_rst_n | output | 1 | Internal core reset, active low |
| op_mode | output | 3 | Operating-mode register |
| pll_pen | output | 1 | PLL-enable control bit |
| nmi_role | output | 1 | High once the shared pin acts as the interrupt request |
| nmi_pending | output | 1 | Sticky non-maskable interrupt request |
| nmi_level | output | 2 | Fixed interrupt priority level |

## Verification
The bench releases reset with the shared pin held low and keeps it low through the role switch. A design that edge-detected against a stale reset-time sample would then raise a false interrupt. It also drops the pin just after core release, inside the switchover window, which would catch a design that arms the detector too early. It makes a new falling edge coincide exactly with an acknowledge; a design that gave the clear priority would lose that request. Finally, it counts the edges up to the release of core reset and up to the role switch, and checks that the straps are captured on exactly that edge, so a counter off by one or a capture at the wrong edge shows up.

// File: rtl/rml_pkg.sv
package rml_pkg;
  localparam int MODE_W = 3;
  typedef logic [MODE_W-1:0] op_mode_t;
  localparam logic [1:0] NMI_PRIO = 2'd3;
endpackage

// File: rtl/rml_sync.sv
module rml_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain[0] <= RESET_VAL;
        else         chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain[i] <= RESET_VAL;
        else         chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rml_reset_gen.sv
module rml_reset_gen #(
  parameter int HOLD_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic ext_rst_n,
  output logic arst_n,
  output logic core_run,
  output logic release_now
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] LAST = HW'(HOLD_CYCLES - 1);

  logic [HW-1:0] hold_cnt;
  logic          done_q;

  rml_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .arst_n (ext_rst_n),
    .d      (1'b1),
    .q      (arst_n)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_cnt <= '0;
      done_q   <= 1'b0;
    end else if (!done_q) begin
      if (hold_cnt == LAST) done_q <= 1'b1;
      else                  hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign release_now = arst_n & ~done_q & (hold_cnt == LAST);
  assign core_run    = done_q;

  // Independent saturating cycle count since synchronized release
  logic [HW-1:0] chk_cnt;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                         chk_cnt <= '0;
    else if (chk_cnt != HW'(HOLD_CYCLES)) chk_cnt <= chk_cnt + 1'b1;
  end

  p_hold_len_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(done_q) |-> chk_cnt == HW'(HOLD_CYCLES));
  p_no_early_run_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (chk_cnt < HW'(HOLD_CYCLES)) |-> !done_q);
endmodule

// File: rtl/rml_mode_latch.sv
module rml_mode_latch
  import rml_pkg::*;
(
  input  logic     clk,
  input  logic     arst_n,
  input  logic     capture,
  input  logic     run,
  input  op_mode_t strap_mode,
  input  logic     pll_strap,
  input  logic     sw_we,
  input  op_mode_t sw_wdata,
  output op_mode_t mode_q,
  output logic     pen_q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode_q <= '0;
      pen_q  <= 1'b0;
    end else if (capture) begin
      mode_q <= strap_mode;
      pen_q  <= pll_strap;
    end else if (run && sw_we) begin
      mode_q <= sw_wdata;
    end
  end

  p_sw_write_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (run && sw_we) |=> mode_q == $past(sw_wdata));
  p_sw_ignored_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (!run && !capture) |=> $stable(mode_q));
  p_pen_hold_r4: assert property (@(posedge clk) disable iff (!arst_n)
    !capture |=> $stable(pen_q));
endmodule

// File: rtl/rml_nmi_ctrl.sv
module rml_nmi_ctrl #(
  parameter int SWITCH_CYCLES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic core_run,
  input  logic pin_n,
  input  logic ack,
  output logic role,
  output logic pending
);
  localparam int SW = $clog2(SWITCH_CYCLES + 1);
  localparam logic [SW-1:0] LAST = SW'(SWITCH_CYCLES - 1);

  logic          pin_s;
  logic          pin_prev;
  logic [SW-1:0] sw_cnt;
  logic          fall;

  rml_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pin_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      (pin_n),
    .q      (pin_s)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pin_prev <= 1'b1;
    else         pin_prev <= pin_s;
  end

  // Switchover timer: the pin leaves its strap role only after the window
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sw_cnt <= '0;
      role   <= 1'b0;
    end else if (!core_run) begin
      sw_cnt <= '0;
      role   <= 1'b0;
    end else if (!role) begin
      if (sw_cnt == LAST) role <= 1'b1;
      else                sw_cnt <= sw_cnt + 1'b1;
    end
  end

  assign fall = role & pin_prev & ~pin_s;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   pending <= 1'b0;
    else if (fall) pending <= 1'b1;
    else if (ack)  pending <= 1'b0;
  end

  logic [SW-1:0] chk_cnt;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                            chk_cnt <= '0;
    else if (!core_run)                     chk_cnt <= '0;
    else if (chk_cnt != SW'(SWITCH_CYCLES)) chk_cnt <= chk_cnt + 1'b1;
  end

  p_switch_delay_r6: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(role) |-> chk_cnt == SW'(SWITCH_CYCLES));
  p_role_needs_run_r6: assert property (@(posedge clk) disable iff (!arst_n)
    !core_run |-> !role);
  p_edge_sets_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (role && pin_prev && !pin_s) |=> pending);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (pending && !ack) |=> pending);
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (pending && ack && !(role && pin_prev && !pin_s)) |=> !pending);
  p_no_early_edge_r10: assert property (@(posedge clk) disable iff (!arst_n)
    !role |-> !pending);
endmodule

// File: rtl/reset_mode_nmi.sv
module reset_mode_nmi
  import rml_pkg::*;
#(
  parameter int HOLD_CYCLES   = 8,
  parameter int SWITCH_CYCLES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              ext_rst_n,
  input  logic              mode_a,
  input  logic              mode_b,
  input  logic              modc_nmi_n,
  input  logic              pll_init,
  input  logic              sw_mode_we,
  input  logic [MODE_W-1:0] sw_mode_wdata,
  input  logic              nmi_ack,
  output logic              core_rst_n,
  output logic [MODE_W-1:0] op_mode,
  output logic              pll_pen,
  output logic              nmi_role,
  output logic              nmi_pending,
  output logic [1:0]        nmi_level
);
  logic     arst_n;
  logic     core_run;
  logic     release_now;
  op_mode_t strap_mode;

  assign strap_mode = {modc_nmi_n, mode_b, mode_a};

  rml_reset_gen #(.HOLD_CYCLES(HOLD_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk         (clk),
    .ext_rst_n   (ext_rst_n),
    .arst_n      (arst_n),
    .core_run    (core_run),
    .release_now (release_now)
  );

  rml_mode_latch u_mode (
    .clk        (clk),
    .arst_n     (arst_n),
    .capture    (release_now),
    .run        (core_run),
    .strap_mode (strap_mode),
    .pll_strap  (pll_init),
    .sw_we      (sw_mode_we),
    .sw_wdata   (sw_mode_wdata),
    .mode_q     (op_mode),
    .pen_q      (pll_pen)
  );

  rml_nmi_ctrl #(.SWITCH_CYCLES(SWITCH_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk     (clk),
    .arst_n  (arst_n),
    .core_run(core_run),
    .pin_n   (modc_nmi_n),
    .ack     (nmi_ack),
    .role    (nmi_role),
    .pending (nmi_pending)
  );

  assign core_rst_n = core_run;
  assign nmi_level  = NMI_PRIO;

  p_reset_hold_r1: assert property (@(posedge clk)
    !ext_rst_n |-> (!core_rst_n && !nmi_role && !nmi_pending && op_mode == '0 && !pll_pen));
  p_mode_capture_r3: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(core_rst_n) |-> op_mode == $past({modc_nmi_n, mode_b, mode_a}));
  p_pen_capture_r4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(core_rst_n) |-> pll_pen == $past(pll_init));
endmodule

// File: tb/reset_mode_nmi_bench.sv
module reset_mode_nmi_bench;
  logic       clk = 1'b0;
  logic       ext_rst_n;
  logic       mode_a, mode_b, modc_nmi_n, pll_init;
  logic       sw_mode_we;
  logic [2:0] sw_mode_wdata;
  logic       nmi_ack;
  logic       core_rst_n;
  logic [2:0] op_mode;
  logic       pll_pen, nmi_role, nmi_pending;
  logic [1:0] nmi_level;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  reset_mode_nmi u_reset_mode_nmi (
    .clk          (clk),
    .ext_rst_n    (ext_rst_n),
    .mode_a       (mode_a),
    .mode_b       (mode_b),
    .modc_nmi_n   (modc_nmi_n),
    .pll_init     (pll_init),
    .sw_mode_we   (sw_mode_we),
    .sw_mode_wdata(sw_mode_wdata),
    .nmi_ack      (nmi_ack),
    .core_rst_n   (core_rst_n),
    .op_mode      (op_mode),
    .pll_pen      (pll_pen),
    .nmi_role     (nmi_role),
    .nmi_pending  (nmi_pending),
    .nmi_level    (nmi_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // Release sequence with edge counting; optionally drop the pin in the switch window
  task automatic do_release(input logic [2:0] m, input logic pen, input logic drop_in_window);
    mode_a = m[0]; mode_b = m[1]; modc_nmi_n = m[2]; pll_init = pen;
    ext_rst_n = 1'b1;
    tick(9);
    chk("R2 core still in reset after 9 edges", core_rst_n, 1'b0);
    tick(1);
    chk("R2 core released after 10 edges", core_rst_n, 1'b1);
    chk("R3 mode captured", op_mode, m);
    chk("R4 pll enable captured", pll_pen, pen);
    if (drop_in_window) modc_nmi_n = 1'b0;
    tick(3);
    chk("R6 role still strap", nmi_role, 1'b0);
    tick(1);
    chk("R6 role switched", nmi_role, 1'b1);
    chk("R10 no pending at switch", nmi_pending, 1'b0);
  endtask

  task automatic t_reset();
    ext_rst_n = 1'b0; #1;
    chk("R1 core reset low", core_rst_n, 1'b0);
    chk("R1 role low", nmi_role, 1'b0);
    chk("R1 pending low", nmi_pending, 1'b0);
    chk("R1 mode zero", op_mode, 3'd0);
    chk("R1 pen zero", pll_pen, 1'b0);
    chk("R11 level", nmi_level, 2'b11);
    @(negedge clk);
  endtask

  task automatic t_sw_in_reset();
    sw_mode_we = 1'b1; sw_mode_wdata = 3'd5;
    tick(2);
    chk("R5 write ignored in reset", op_mode, 3'd0);
    sw_mode_we = 1'b0;
  endtask

  task automatic t_nmi_edge();
    modc_nmi_n = 1'b0;
    tick(2);
    chk("R7 not yet pending", nmi_pending, 1'b0);
    tick(1);
    chk("R7 pending after 3 edges", nmi_pending, 1'b1);
    modc_nmi_n = 1'b1;
    tick(6);
    chk("R8 pending sticky", nmi_pending, 1'b1);
    nmi_ack = 1'b1; tick(1); nmi_ack = 1'b0;
    chk("R9 ack clears", nmi_pending, 1'b0);
    tick(2);
    chk("R9 stays clear", nmi_pending, 1'b0);
  endtask

  task automatic t_ack_collide();
    modc_nmi_n = 1'b0; tick(3);
    chk("R7 first edge pending", nmi_pending, 1'b1);
    modc_nmi_n = 1'b1; tick(3);
    modc_nmi_n = 1'b0;
    tick(2);
    nmi_ack = 1'b1;
    tick(1);
    nmi_ack = 1'b0;
    chk("R9 edge with ack keeps flag", nmi_pending, 1'b1);
    nmi_ack = 1'b1; tick(1); nmi_ack = 1'b0;
    chk("R9 later ack clears", nmi_pending, 1'b0);
    modc_nmi_n = 1'b1; tick(3);
    chk("R7 rising edge ignored", nmi_pending, 1'b0);
  endtask

  task automatic t_sw_write();
    sw_mode_we = 1'b1; sw_mode_wdata = 3'b010;
    tick(1);
    sw_mode_we = 1'b0;
    chk("R5 write applied", op_mode, 3'b010);
    tick(2);
    chk("R5 write held", op_mode, 3'b010);
  endtask

  task automatic t_reassert();
    modc_nmi_n = 1'b0; tick(3);
    chk("R7 pending before reassert", nmi_pending, 1'b1);
    modc_nmi_n = 1'b1; tick(1);
    ext_rst_n = 1'b0; #1;
    chk("R1 pending cleared by reset", nmi_pending, 1'b0);
    chk("R6 role back to strap", nmi_role, 1'b0);
    chk("R1 core reset reasserted", core_rst_n, 1'b0);
    chk("R1 mode cleared", op_mode, 3'd0);
    tick(2);
  endtask

  task automatic t_low_through_switch();
    do_release(3'b010, 1'b1, 1'b0);
    tick(4);
    chk("R10 low level at switch no edge", nmi_pending, 1'b0);
    modc_nmi_n = 1'b1; tick(4);
    chk("R7 rise after switch ignored", nmi_pending, 1'b0);
  endtask

  task automatic t_drop_in_window();
    ext_rst_n = 1'b0; tick(2);
    do_release(3'b111, 1'b1, 1'b1);
    tick(4);
    chk("R10 edge in window ignored", nmi_pending, 1'b0);
    modc_nmi_n = 1'b1; tick(4);
    modc_nmi_n = 1'b0; tick(3);
    chk("R7 edge after window taken", nmi_pending, 1'b1);
  endtask

  initial begin
    ext_rst_n = 1'b0; mode_a = 1'b0; mode_b = 1'b0; modc_nmi_n = 1'b1;
    pll_init = 1'b0; sw_mode_we = 1'b0; sw_mode_wdata = 3'd0; nmi_ack = 1'b0;
    tick(3);
    t_reset();
    t_sw_in_reset();
    do_release(3'b101, 1'b0, 1'b0);
    t_nmi_edge();
    t_ack_collide();
    t_sw_write();
    t_reassert();
    t_low_through_switch();
    t_drop_in_window();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule